// File: doc/BRIEF.md
# Dual-Priority Descriptor Ring Engine

This block runs the descriptor rings of one CPU-side port of a packet switch. There are four rings, each in a small synchronous descriptor memory: transmit-high, transmit-low, receive-high and receive-low. For every descriptor the engine reads four words and checks the ownership flag. It then issues one or two buffer transfer requests to an external byte mover. Last, it writes the first word back with ownership returned to software.

Software fills descriptors at consecutive four-word slots from a ring base and sets the ownership flag. A flag on a descriptor marks the end of its ring. When a transmit ring has nothing ready, the engine waits a programmable number of cycles before it looks at that ring again. Received frames are announced with a request pulse that gives the length, the priority and the source code. Each frame goes to the ring that matches its priority. If that ring has no free descriptor, the engine raises a full pulse and drops the frame.

Descriptor layout, in words from the descriptor address:
- Word 0 is the status word. It holds the length in [15:0], the source code in [26:24], the error flag in [27], the last-of-packet flag in [28], the first-of-packet flag in [29], the ring-end flag in [30] and the ownership flag in [31].
- Word 1 holds the second buffer's capacity in [31:16] and the first buffer's capacity in [15:0].
- Word 2 is the first buffer pointer.
- Word 3 is the second buffer pointer.

Top module: `desc_ring_engine`

## Requirements
- R1: While reset is held, no memory read, memory write or buffer request is issued, and no event pulse is raised.
- R2: A descriptor with the ownership flag (word 0 bit 31) at 0 causes no buffer request. After a transmit ring is found not ready, word 0 of that ring's head is not read again for at least `pollGap` cycles. When software later sets the flag, the ring is served.
- R3: Descriptors of a ring are used in order, at word address base + 4 × index. After a descriptor whose ring-end flag (word 0 bit 30) is set, the next fetch on that ring goes to the base again.
- R4: For a length L and a first-buffer capacity C1, the first request carries the first buffer pointer and min(L, C1) bytes. If L > C1, a second request follows with the second buffer pointer and the remaining L − C1 bytes. Transmit requests are reads (bufWrite = 0) and receive requests are writes (bufWrite = 1).
- R5: Write-back goes to word 0 and clears the ownership flag. On transmit, every other bit is kept except the error flag. On receive, the word becomes ring-end kept, first and last flags set, error flag, source code in [26:24] and the frame length in [15:0], with all other bits 0.
- R6: At a packet boundary, when both transmit rings hold ready descriptors, the high ring is served first.
- R7: After a transmit descriptor whose last-of-packet flag (word 0 bit 28) is 0, the next descriptor served is the next one on the same ring, even when the other transmit ring becomes ready.
- R8: A receive request with rxHigh = 1 uses the receive-high ring, and any other request uses the receive-low ring. If the chosen descriptor is not owned by hardware, a single rxFullHi or rxFullLo pulse is raised, no transfer happens and the descriptor is left unchanged.
- R9: If the length exceeds the sum of both buffer capacities, no buffer request is made. txErr or rxErr pulses once, and word 0 is written back with the ownership flag cleared and the error flag (bit 27) set.
- R10: A descriptor completed without error raises exactly one of txDoneHi, txDoneLo, rxDoneHi or rxDoneLo, matching its ring. At most one event pulse is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baseTxHi | input | AW | Word address of the transmit-high ring |
| baseTxLo | input | AW | Word address of the transmit-low ring |
| baseRxHi | input | AW | Word address of the receive-high ring |
| baseRxLo | input | AW | Word address of the receive-low ring |
| pollGap | input | PW | Idle cycles before a transmit ring that was not ready is looked at again |
| memRe | output | 1 | Descriptor memory read strobe; data returns one cycle later |
| memWe | output | 1 | Descriptor memory write strobe |
| memAddr | output | AW | Descriptor memory word address |
| memWdata | output | 32 | Write-back word |
| memRdata | input | 32 | Read data, valid the cycle after memRe |
| rxReq | input | 1 | Pulse announcing a received frame |
| rxHigh | input | 1 | Priority of the announced frame |
| rxLen | input | LW | Byte length of the announced frame |
| rxSrc | input | SW | Source code of the announced frame |
| bufReqValid | output | 1 | Buffer transfer request, held until bufDone |
| bufWrite | output | 1 | 1 means write into memory (receive), 0 means read (transmit) |
| bufAddr | output | 32 | Buffer pointer of the request |
| bufLen | output | LW | Byte count of the request |
| bufDone | input | 1 | Pulse when the mover finishes the current request |
| txDoneHi | output | 1 | Transmit-high descriptor completed |
| txDoneLo | output | 1 | Transmit-low descriptor completed |
| rxDoneHi | output | 1 | Receive-high descriptor completed |
| rxDoneLo | output | 1 | Receive-low descriptor completed |
| rxFullHi | output | 1 | Receive-high ring had no free descriptor |
| rxFullLo | output | 1 | Receive-low ring had no free descriptor |
| txErr | output | 1 | Transmit descriptor length error |
| rxErr | output | 1 | Receive descriptor length error |

## Verification
The hardest case to reach from the ports is the rule that keeps a packet on one ring (R7). The high ring must become ready while a multi-descriptor low packet is already under way, because if it is ready at the start, it wins anyway. The bench starts with the high head not owned and a short poll gap. It waits for the first buffer request of the low packet, then hands the high descriptor to hardware in the middle of that transfer. It then expects the low packet's second descriptor before the high one. The ring-end case is reached in a similar way. The bench leaves the slot after the ring-end descriptor armed and watches for a period in which no request may appear. It then re-arms the base slot.

// File: rtl/dre_pkg.sv
package dre_pkg;
  localparam int DESC_W   = 32;
  localparam int F_OWN    = 31;
  localparam int F_END    = 30;
  localparam int F_SOP    = 29;
  localparam int F_EOP    = 28;
  localparam int F_ERR    = 27;
  localparam int F_SRC    = 24;
  localparam int N_RINGS  = 4;

  localparam logic [1:0] RING_TXH = 2'd0;
  localparam logic [1:0] RING_TXL = 2'd1;
  localparam logic [1:0] RING_RXH = 2'd2;
  localparam logic [1:0] RING_RXL = 2'd3;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_DECIDE, ST_BUF1, ST_BUF2, ST_WB
  } state_e;

  typedef struct packed {
    logic       setRing;
    logic [1:0] ring;
    logic [1:0] rdWord;
    logic       capture;
    logic [1:0] capWord;
    logic       useBuf2;
    logic       advance;
    logic       rxLatch;
  } strobe_t;
endpackage

// File: rtl/dre_datapath.sv
module dre_datapath
  import dre_pkg::*;
#(
  parameter int AW = 8,
  parameter int LW = 16,
  parameter int IW = 3,
  parameter int SW = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           s,
  input  logic [AW-1:0]     baseTxHi,
  input  logic [AW-1:0]     baseTxLo,
  input  logic [AW-1:0]     baseRxHi,
  input  logic [AW-1:0]     baseRxLo,
  input  logic [DESC_W-1:0] memRdata,
  input  logic [LW-1:0]     rxLen,
  input  logic [SW-1:0]     rxSrc,
  output logic [AW-1:0]     memAddr,
  output logic [DESC_W-1:0] memWdata,
  output logic [DESC_W-1:0] bufAddr,
  output logic [LW-1:0]     bufLen,
  output logic              bufWrite,
  output logic [1:0]        curRing,
  output logic              own,
  output logic              eop,
  output logic              lenErr,
  output logic              needBuf2
);
  logic [AW-1:0]     baseArr [N_RINGS];
  logic [IW-1:0]     idxQ    [N_RINGS];
  logic [DESC_W-1:0] wQ      [4];
  logic [LW-1:0]     rxLenQ;
  logic [SW-1:0]     rxSrcQ;
  logic [AW-1:0]     descAddr;
  logic [LW-1:0]     curLen, buf1Len, buf2Len, len1, len2;
  logic [LW:0]       sumLen;
  logic [DESC_W-1:0] wbWord;

  assign baseArr[RING_TXH] = baseTxHi;
  assign baseArr[RING_TXL] = baseTxLo;
  assign baseArr[RING_RXH] = baseRxHi;
  assign baseArr[RING_RXL] = baseRxLo;

  always_ff @(posedge clk) begin
    if (rst) begin
      curRing <= RING_TXH;
      rxLenQ  <= '0;
      rxSrcQ  <= '0;
      for (int k = 0; k < 4; k++) wQ[k] <= '0;
    end else begin
      if (s.setRing) curRing <= s.ring;
      if (s.capture) wQ[s.capWord] <= memRdata;
      if (s.rxLatch) begin
        rxLenQ <= rxLen;
        rxSrcQ <= rxSrc;
      end
    end
  end

  for (genvar g = 0; g < N_RINGS; g++) begin : g_idx
    always_ff @(posedge clk) begin
      if (rst) idxQ[g] <= '0;
      else if (s.advance && curRing == 2'(g))
        idxQ[g] <= wQ[0][F_END] ? '0 : idxQ[g] + 1'b1;
    end
  end

  assign descAddr = baseArr[curRing] + AW'({idxQ[curRing], 2'b00});
  assign memAddr  = descAddr + AW'(s.rdWord);

  assign curLen   = curRing[1] ? rxLenQ : wQ[0][LW-1:0];
  assign buf1Len  = wQ[1][LW-1:0];
  assign buf2Len  = wQ[1][2*LW-1:LW];
  assign sumLen   = {1'b0, buf1Len} + {1'b0, buf2Len};
  assign lenErr   = {1'b0, curLen} > sumLen;
  assign len1     = (curLen > buf1Len) ? buf1Len : curLen;
  assign len2     = curLen - len1;
  assign needBuf2 = len2 != '0;
  assign own      = wQ[0][F_OWN];
  assign eop      = wQ[0][F_EOP];

  assign bufAddr  = s.useBuf2 ? wQ[3] : wQ[2];
  assign bufLen   = s.useBuf2 ? len2 : len1;
  assign bufWrite = curRing[1];

  always_comb begin
    if (curRing[1]) begin
      wbWord              = '0;
      wbWord[F_END]       = wQ[0][F_END];
      wbWord[F_SOP]       = 1'b1;
      wbWord[F_EOP]       = 1'b1;
      wbWord[F_SRC +: SW] = rxSrcQ;
      wbWord[LW-1:0]      = rxLenQ;
    end else begin
      wbWord = wQ[0];
    end
    wbWord[F_OWN] = 1'b0;
    wbWord[F_ERR] = lenErr;
  end
  assign memWdata = wbWord;

  // R3: a ring-end descriptor sends that ring's index back to zero
  a_r3_ring_wrap: assert property (@(posedge clk) disable iff (rst)
    (s.advance && wQ[0][F_END]) |=> (idxQ[$past(curRing)] == '0));
endmodule

// File: rtl/dre_control.sv
module dre_control
  import dre_pkg::*;
#(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rxReq,
  input  logic          rxHigh,
  input  logic [PW-1:0] pollGap,
  input  logic          own,
  input  logic          eop,
  input  logic          lenErr,
  input  logic          needBuf2,
  input  logic [1:0]    curRing,
  input  logic          bufDone,
  output strobe_t       s,
  output logic          memRe,
  output logic          memWe,
  output logic          bufReqValid,
  output logic [7:0]    ev
);
  state_e        state, nextState;
  logic [2:0]    cnt;
  logic          rxPend, rxHiQ, inPkt, pktLo;
  logic [PW-1:0] timerQ [2];
  logic [1:0]    pick;
  logic          pickOk;
  logic          stall;

  assign stall = (state == ST_DECIDE) && !own;

  always_comb begin
    s           = '0;
    memRe       = 1'b0;
    memWe       = 1'b0;
    bufReqValid = 1'b0;
    ev          = '0;
    pick        = RING_TXH;
    pickOk      = 1'b0;
    nextState   = state;
    s.rxLatch   = rxReq && !rxPend;
    case (state)
      ST_IDLE: begin
        if (rxPend) begin
          pickOk = 1'b1;
          pick   = {1'b1, ~rxHiQ};
        end else if (inPkt) begin
          pickOk = timerQ[pktLo] == '0;
          pick   = {1'b0, pktLo};
        end else if (timerQ[0] == '0) begin
          pickOk = 1'b1;
          pick   = RING_TXH;
        end else if (timerQ[1] == '0) begin
          pickOk = 1'b1;
          pick   = RING_TXL;
        end
        s.setRing = pickOk;
        s.ring    = pick;
        if (pickOk) nextState = ST_FETCH;
      end
      ST_FETCH: begin
        memRe     = cnt < 3'd4;
        s.rdWord  = cnt[1:0];
        s.capture = cnt != 3'd0;
        s.capWord = cnt[1:0] - 2'd1;
        if (cnt == 3'd4) nextState = ST_DECIDE;
      end
      ST_DECIDE: begin
        if (!own) begin
          if (curRing[1]) ev[4 + int'(curRing[0])] = 1'b1;
          nextState = ST_IDLE;
        end else if (lenErr) begin
          nextState = ST_WB;
        end else begin
          nextState = ST_BUF1;
        end
      end
      ST_BUF1: begin
        bufReqValid = 1'b1;
        if (bufDone) nextState = needBuf2 ? ST_BUF2 : ST_WB;
      end
      ST_BUF2: begin
        bufReqValid = 1'b1;
        s.useBuf2   = 1'b1;
        if (bufDone) nextState = ST_WB;
      end
      ST_WB: begin
        memWe     = 1'b1;
        s.advance = 1'b1;
        if (lenErr) ev[curRing[1] ? 7 : 6] = 1'b1;
        else        ev[curRing] = 1'b1;
        nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      rxPend <= 1'b0;
      rxHiQ  <= 1'b0;
      inPkt  <= 1'b0;
      pktLo  <= 1'b0;
    end else begin
      state <= nextState;
      cnt   <= (state == ST_FETCH) ? cnt + 3'd1 : 3'd0;
      if (s.rxLatch) begin
        rxPend <= 1'b1;
        rxHiQ  <= rxHigh;
      end else if (curRing[1] && (stall || state == ST_WB)) begin
        rxPend <= 1'b0;
      end
      if (state == ST_WB && !curRing[1]) begin
        inPkt <= !eop;
        pktLo <= curRing[0];
      end
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_poll
    always_ff @(posedge clk) begin
      if (rst) timerQ[g] <= '0;
      else if (stall && curRing == 2'(g)) timerQ[g] <= pollGap;
      else if (timerQ[g] != '0) timerQ[g] <= timerQ[g] - 1'b1;
    end
  end

  // R10: never two events in one cycle
  a_r10_single_event: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ev));
  // R4: a buffer request stays up until the mover finishes it
  a_r4_req_held: assert property (@(posedge clk) disable iff (rst)
    (bufReqValid && !bufDone) |=> bufReqValid);
endmodule

// File: rtl/desc_ring_engine.sv
module desc_ring_engine
  import dre_pkg::*;
#(
  parameter int AW = 8,
  parameter int LW = 16,
  parameter int IW = 3,
  parameter int SW = 3,
  parameter int PW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [AW-1:0]     baseTxHi,
  input  logic [AW-1:0]     baseTxLo,
  input  logic [AW-1:0]     baseRxHi,
  input  logic [AW-1:0]     baseRxLo,
  input  logic [PW-1:0]     pollGap,
  output logic              memRe,
  output logic              memWe,
  output logic [AW-1:0]     memAddr,
  output logic [DESC_W-1:0] memWdata,
  input  logic [DESC_W-1:0] memRdata,
  input  logic              rxReq,
  input  logic              rxHigh,
  input  logic [LW-1:0]     rxLen,
  input  logic [SW-1:0]     rxSrc,
  output logic              bufReqValid,
  output logic              bufWrite,
  output logic [DESC_W-1:0] bufAddr,
  output logic [LW-1:0]     bufLen,
  input  logic              bufDone,
  output logic              txDoneHi,
  output logic              txDoneLo,
  output logic              rxDoneHi,
  output logic              rxDoneLo,
  output logic              rxFullHi,
  output logic              rxFullLo,
  output logic              txErr,
  output logic              rxErr
);
  strobe_t    strobes;
  logic [1:0] curRing;
  logic       own, eop, lenErr, needBuf2;
  logic [7:0] ev;

  dre_datapath #(.AW(AW), .LW(LW), .IW(IW), .SW(SW)) u_dp (
    .clk(clk), .rst(rst), .s(strobes),
    .baseTxHi(baseTxHi), .baseTxLo(baseTxLo),
    .baseRxHi(baseRxHi), .baseRxLo(baseRxLo),
    .memRdata(memRdata), .rxLen(rxLen), .rxSrc(rxSrc),
    .memAddr(memAddr), .memWdata(memWdata),
    .bufAddr(bufAddr), .bufLen(bufLen), .bufWrite(bufWrite),
    .curRing(curRing), .own(own), .eop(eop),
    .lenErr(lenErr), .needBuf2(needBuf2)
  );

  dre_control #(.PW(PW)) u_ctl (
    .clk(clk), .rst(rst), .rxReq(rxReq), .rxHigh(rxHigh),
    .pollGap(pollGap), .own(own), .eop(eop), .lenErr(lenErr),
    .needBuf2(needBuf2), .curRing(curRing), .bufDone(bufDone),
    .s(strobes), .memRe(memRe), .memWe(memWe),
    .bufReqValid(bufReqValid), .ev(ev)
  );

  assign {rxErr, txErr, rxFullLo, rxFullHi,
          rxDoneLo, rxDoneHi, txDoneLo, txDoneHi} = ev;

  // R5: every write-back hands the descriptor to software
  a_r5_wb_own_clear: assert property (@(posedge clk) disable iff (rst)
    memWe |-> !memWdata[F_OWN]);
  // R9: an oversize length never reaches the buffer mover
  a_r9_no_buf_on_err: assert property (@(posedge clk) disable iff (rst)
    bufReqValid |-> !lenErr);
endmodule

// File: tb/desc_ring_engine_tb.sv
`timescale 1ns/1ps
module desc_ring_engine_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  baseTxHi = 8'h00, baseTxLo = 8'h20, baseRxHi = 8'h40, baseRxLo = 8'h60;
  logic [7:0]  pollGap = 8'd4;
  logic        memRe, memWe;
  logic [7:0]  memAddr;
  logic [31:0] memWdata, memRdata = '0;
  logic        rxReq = 1'b0, rxHigh = 1'b0;
  logic [15:0] rxLen = '0;
  logic [2:0]  rxSrc = '0;
  logic        bufReqValid, bufWrite, bufDone = 1'b0;
  logic [31:0] bufAddr;
  logic [15:0] bufLen;
  logic txDoneHi, txDoneLo, rxDoneHi, rxDoneLo, rxFullHi, rxFullLo, txErr, rxErr;

  logic [31:0] mem [256];
  logic [63:0] expReq [$];
  int          expEv [$];
  int checks = 0, errors = 0, cycle = 0, waitCnt = 0;
  bit reqOpen = 0, trackReads = 0;
  int hiLast = -1, hiMin = 100000, hiCount = 0;

  always #2 clk = ~clk;

  desc_ring_engine u_dut (
    .clk(clk), .rst(rst), .baseTxHi(baseTxHi), .baseTxLo(baseTxLo),
    .baseRxHi(baseRxHi), .baseRxLo(baseRxLo), .pollGap(pollGap),
    .memRe(memRe), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .rxReq(rxReq), .rxHigh(rxHigh), .rxLen(rxLen),
    .rxSrc(rxSrc), .bufReqValid(bufReqValid), .bufWrite(bufWrite),
    .bufAddr(bufAddr), .bufLen(bufLen), .bufDone(bufDone),
    .txDoneHi(txDoneHi), .txDoneLo(txDoneLo), .rxDoneHi(rxDoneHi),
    .rxDoneLo(rxDoneLo), .rxFullHi(rxFullHi), .rxFullLo(rxFullLo),
    .txErr(txErr), .rxErr(rxErr)
  );

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // descriptor memory: one-cycle read latency
  initial forever begin
    @(posedge clk);
    if (memWe) mem[memAddr] <= memWdata;
    if (memRe) memRdata <= mem[memAddr];
  end

  // per-clock comparison against the expected streams, plus the buffer mover
  initial forever begin
    logic [7:0]  evv;
    logic [63:0] got;
    @(negedge clk);
    cycle++;
    if (!rst) begin
      if (bufReqValid && !reqOpen) begin
        got = {bufAddr, 15'b0, bufWrite, bufLen};
        reqOpen = 1;
        if (expReq.size() == 0) chk(0, "R4", "unexpected buffer request", got, 0);
        else begin
          logic [63:0] e;
          e = expReq.pop_front();
          chk(got == e, "R4", "buffer request", got, e);
        end
      end
      evv = {rxErr, txErr, rxFullLo, rxFullHi, rxDoneLo, rxDoneHi, txDoneLo, txDoneHi};
      for (int k = 0; k < 8; k++) begin
        if (evv[k]) begin
          string tag;
          tag = (k < 4) ? "R10" : (k < 6) ? "R8" : "R9";
          if (expEv.size() == 0) chk(0, tag, "unexpected event", k, 99);
          else begin
            int e;
            e = expEv.pop_front();
            chk(e == k, tag, "event kind", k, e);
          end
        end
      end
      if (trackReads && memRe && memAddr == 8'h00) begin
        if (hiLast >= 0 && cycle - hiLast < hiMin) hiMin = cycle - hiLast;
        hiLast = cycle;
        hiCount++;
      end
      if (bufDone) bufDone = 1'b0;
      else if (bufReqValid) begin
        waitCnt++;
        if (waitCnt == 3) begin
          bufDone = 1'b1;
          reqOpen = 0;
          waitCnt = 0;
        end
      end
    end else begin
      bufDone = 1'b0;
      reqOpen = 0;
      waitCnt = 0;
    end
  end

  initial begin
    wait (cycle > 150000);
    chk(0, "R10", "watchdog expired", cycle, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  function automatic logic [31:0] txw(logic [15:0] len, bit ownF, bit endF, bit sop, bit eopF);
    return {ownF, endF, sop, eopF, 12'b0, len};
  endfunction
  function automatic logic [31:0] rxwb(logic [15:0] len, logic [2:0] src, bit err, bit endF);
    return {1'b0, endF, 1'b1, 1'b1, err, src, 8'h00, len};
  endfunction
  function automatic logic [63:0] rq(logic [31:0] a, bit wr, logic [15:0] l);
    return {a, 15'b0, wr, l};
  endfunction

  task automatic setDesc(logic [7:0] a, logic [31:0] w0, logic [31:0] w1,
                         logic [31:0] w2, logic [31:0] w3);
    mem[a] = w0; mem[a+1] = w1; mem[a+2] = w2; mem[a+3] = w3;
  endtask

  task automatic startScen(logic [7:0] gap);
    @(negedge clk);
    rst = 1'b1;
    pollGap = gap;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    expReq.delete();
    expEv.delete();
    repeat (2) @(negedge clk);
  endtask

  task automatic go();
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic drain(string tag);
    int n = 0;
    while ((expReq.size() != 0 || expEv.size() != 0) && n < 3000) begin
      @(negedge clk);
      n++;
    end
    chk(n < 3000, tag, "expected activity completed", expReq.size() + expEv.size(), 0);
    repeat (4) @(negedge clk);
  endtask

  task automatic sendRx(bit hi, logic [15:0] len, logic [2:0] src);
    @(negedge clk);
    rxReq = 1'b1; rxHigh = hi; rxLen = len; rxSrc = src;
    @(negedge clk);
    rxReq = 1'b0;
  endtask

  initial begin
    // R1: quiet during reset
    startScen(8'd4);
    chk(memRe == 0, "R1", "memRe in reset", memRe, 0);
    chk(memWe == 0, "R1", "memWe in reset", memWe, 0);
    chk(bufReqValid == 0, "R1", "bufReqValid in reset", bufReqValid, 0);
    chk({rxErr, txErr, rxFullLo, rxFullHi, rxDoneLo, rxDoneHi, txDoneLo, txDoneHi} == 0,
        "R1", "events in reset", 0, 0);

    // R3 R4 R5 R10: two high descriptors, second one split over both buffers
    startScen(8'd4);
    setDesc(8'h00, txw(16'd40, 1, 0, 1, 1), {16'd64, 16'd64}, 32'h1000, 32'h2000);
    setDesc(8'h04, txw(16'd100, 1, 0, 1, 1), {16'd64, 16'd60}, 32'h3000, 32'h4000);
    expReq.push_back(rq(32'h1000, 0, 16'd40));
    expReq.push_back(rq(32'h3000, 0, 16'd60));
    expReq.push_back(rq(32'h4000, 0, 16'd40));
    expEv.push_back(0); expEv.push_back(0);
    go();
    drain("R3");
    chk(mem[8'h00] == txw(16'd40, 0, 0, 1, 1), "R5", "tx write-back d0", mem[8'h00], txw(16'd40, 0, 0, 1, 1));
    chk(mem[8'h04] == txw(16'd100, 0, 0, 1, 1), "R5", "tx write-back d1", mem[8'h04], txw(16'd100, 0, 0, 1, 1));

    // R6: both transmit rings ready, high first
    startScen(8'd4);
    setDesc(8'h00, txw(16'd10, 1, 0, 1, 1), {16'd64, 16'd64}, 32'h5000, 32'h0);
    setDesc(8'h20, txw(16'd12, 1, 0, 1, 1), {16'd64, 16'd64}, 32'h6000, 32'h0);
    expReq.push_back(rq(32'h5000, 0, 16'd10));
    expReq.push_back(rq(32'h6000, 0, 16'd12));
    expEv.push_back(0); expEv.push_back(1);
    go();
    drain("R6");

    // R7: high ring becomes ready in the middle of a low multi-descriptor packet
    startScen(8'd2);
    setDesc(8'h20, txw(16'd8, 1, 0, 1, 0), {16'd64, 16'd64}, 32'h7000, 32'h0);
    setDesc(8'h24, txw(16'd9, 1, 0, 0, 1), {16'd64, 16'd64}, 32'h7100, 32'h0);
    setDesc(8'h00, txw(16'd5, 0, 0, 1, 1), {16'd64, 16'd64}, 32'h7200, 32'h0);
    expReq.push_back(rq(32'h7000, 0, 16'd8));
    expReq.push_back(rq(32'h7100, 0, 16'd9));
    expReq.push_back(rq(32'h7200, 0, 16'd5));
    expEv.push_back(1); expEv.push_back(1); expEv.push_back(0);
    go();
    do @(negedge clk); while (!bufReqValid);
    mem[8'h00][31] = 1'b1;
    drain("R7");

    // R3: ring end returns to the base slot
    startScen(8'd4);
    setDesc(8'h20, txw(16'd16, 1, 1, 1, 1), {16'd64, 16'd64}, 32'h8000, 32'h0);
    setDesc(8'h24, txw(16'd16, 1, 0, 1, 1), {16'd64, 16'd64}, 32'h8800, 32'h0);
    expReq.push_back(rq(32'h8000, 0, 16'd16));
    expEv.push_back(1);
    go();
    drain("R3");
    repeat (40) @(negedge clk);
    mem[8'h20] = txw(16'd20, 1, 1, 1, 1);
    mem[8'h22] = 32'h8400;
    expReq.push_back(rq(32'h8400, 0, 16'd20));
    expEv.push_back(1);
    drain("R3");
    chk(mem[8'h24][31] == 1'b1, "R3", "slot after ring end untouched", mem[8'h24][31], 1);

    // R2: idle polling interval, then a late hand-over is served
    startScen(8'd20);
    go();
    trackReads = 1;
    repeat (300) @(negedge clk);
    trackReads = 0;
    chk(hiCount >= 3, "R2", "high ring re-polled", hiCount, 3);
    chk(hiMin >= 20, "R2", "minimum poll spacing", hiMin, 20);
    setDesc(8'h00, txw(16'd4, 1, 0, 1, 1), {16'd64, 16'd64}, 32'h9000, 32'h0);
    expReq.push_back(rq(32'h9000, 0, 16'd4));
    expEv.push_back(0);
    drain("R2");

    // R8 R4 R5: receive high single buffer, receive low split
    startScen(8'd4);
    setDesc(8'h40, 32'h8000_0000, {16'd64, 16'd64}, 32'hA000, 32'h0);
    setDesc(8'h60, 32'h8000_0000, {16'd50, 16'd50}, 32'hB000, 32'hB800);
    go();
    expReq.push_back(rq(32'hA000, 1, 16'd30));
    expEv.push_back(2);
    sendRx(1, 16'd30, 3'd1);
    drain("R8");
    chk(mem[8'h40] == rxwb(16'd30, 3'd1, 0, 0), "R5", "rx high write-back", mem[8'h40], rxwb(16'd30, 3'd1, 0, 0));
    expReq.push_back(rq(32'hB000, 1, 16'd50));
    expReq.push_back(rq(32'hB800, 1, 16'd40));
    expEv.push_back(3);
    sendRx(0, 16'd90, 3'd0);
    drain("R8");
    chk(mem[8'h60] == rxwb(16'd90, 3'd0, 0, 0), "R5", "rx low write-back", mem[8'h60], rxwb(16'd90, 3'd0, 0, 0));

    // R8: no free receive descriptor
    startScen(8'd4);
    setDesc(8'h60, 32'h0000_0011, {16'd64, 16'd64}, 32'hC000, 32'h0);
    go();
    expEv.push_back(5);
    sendRx(0, 16'd20, 3'd0);
    drain("R8");
    chk(mem[8'h60] == 32'h0000_0011, "R8", "full descriptor untouched", mem[8'h60], 32'h11);
    expEv.push_back(4);
    sendRx(1, 16'd20, 3'd0);
    drain("R8");

    // R9: length errors on both directions
    startScen(8'd4);
    setDesc(8'h00, txw(16'd200, 1, 0, 1, 1), {16'd64, 16'd60}, 32'hD000, 32'hD800);
    setDesc(8'h40, 32'h8000_0000, {16'd50, 16'd50}, 32'hE000, 32'hE800);
    expEv.push_back(6);
    go();
    drain("R9");
    chk(mem[8'h00] == (txw(16'd200, 0, 0, 1, 1) | 32'h0800_0000), "R9", "tx error write-back",
        mem[8'h00], txw(16'd200, 0, 0, 1, 1) | 32'h0800_0000);
    expEv.push_back(7);
    sendRx(1, 16'd150, 3'd2);
    drain("R9");
    chk(mem[8'h40] == rxwb(16'd150, 3'd2, 1, 0), "R9", "rx error write-back", mem[8'h40], rxwb(16'd150, 3'd2, 1, 0));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule